// File: doc/BRIEF.md
# Three-Product Sequential Unsigned Multiplier

This block forms the full 64-bit unsigned product of two 32-bit operands with one shared 16x16 unsigned multiplier that it uses over three successive cycles. Each operand is split into a high half and a low half. The block first forms the high-times-high product, then the low-times-low product. It then multiplies the magnitudes of the two half differences. The cross term is rebuilt by adding this third product to the sum of the first two, or by subtracting it from that sum. Two comparisons of the halves choose which. This saves the fourth multiplication that a schoolbook split would need.

A client drives the operands with a one-cycle `start` pulse while `busy` is low. The block latches the operands, runs its sequence, and raises `done` for one cycle with the result on `prod_hi` and `prod_lo`. The result words hold until the next accepted operation writes a new result.

The controller has five states. IDLE waits for `start`, and on `start` it latches the operands and moves to HIHI. HIHI forms the high-half product and moves to LOLO. LOLO forms the low-half product and moves to CROSS. CROSS forms the difference product, merges the middle term, registers the result and moves to FIN. FIN raises `done` and returns to IDLE. Every state apart from IDLE moves on without condition.

Top module: `karat_mul`

## Requirements
- R1: After an accepted start, `{prod_hi, prod_lo}` equals the exact unsigned product of the latched operands, with bits 63:32 on `prod_hi` and bits 31:0 on `prod_lo`.
- R2: A start sampled high on a rising edge while `busy` is low is accepted. `done` is then high during the fourth cycle that follows that edge.
- R3: `done` is high for exactly one cycle. In the cycle after it, `done` and `busy` are both low.
- R4: A start that arrives while `busy` is high is ignored. The operands latched at acceptance are kept, and the result is their product.
- R5: `prod_hi` and `prod_lo` change only in the cycle in which `done` is high. Between operations they hold their value whatever the operand inputs do.
- R6: The product is exact when both half comparisons point the same way (high half above low half in both operands, or below it in both). In this case the difference product is subtracted.
- R7: The product is exact when the two half comparisons point opposite ways. In this case the difference product is added.
- R8: The product is exact when the two halves of either operand are equal, so that the difference product is zero.
- R9: The product is exact for the extreme operands: zero with zero, zero with all ones, and all ones with all ones. In the last case the middle sum exceeds 32 bits.
- R10: While reset is held, and after it is released, `busy`, `done`, `prod_hi` and `prod_lo` are all zero until the first start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a multiplication; taken only while idle |
| opx | input | 32 | First operand |
| opy | input | 32 | Second operand |
| busy | output | 1 | High from acceptance until the cycle with `done` |
| done | output | 1 | One-cycle pulse when the result is valid |
| prod_hi | output | 32 | Upper 32 bits of the product |
| prod_lo | output | 32 | Lower 32 bits of the product |

## Verification
The operands are chosen so that each of the four pairings of the half comparisons occurs at least once. This separates a fault in the add/subtract choice from a fault in the difference magnitudes. Operands with equal halves exercise the tie, where a wrong direction bit would do no harm but a wrong magnitude would still show. Zero and all-ones operands reach both the smallest result and the largest middle sum, which exposes a truncated middle accumulator or a lost carry in the final merge. Random operands, a start pulse sent during a busy operation, and idle cycles with changing inputs check the general arithmetic, the rejection of a second start, and that the result holds.

// File: rtl/kmul_pkg.sv
package kmul_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;
    localparam int PROD_W = 2 * WORD_W;
    localparam int MID_W  = WORD_W + 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HIHI,
        S_LOLO,
        S_CROSS,
        S_FIN
    } kstate_t;
endpackage

// File: rtl/kmul_absdiff.sv
module kmul_absdiff #(
    parameter int W = 16
) (
    input  logic [W-1:0] upper,
    input  logic [W-1:0] lower,
    output logic [W-1:0] mag,
    output logic         upper_ge
);
    always_comb begin
        upper_ge = (upper >= lower);
        if (upper_ge) begin
            mag = upper - lower;
        end else begin
            mag = lower - upper;
        end
    end
endmodule

// File: rtl/kmul_mult.sv
module kmul_mult #(
    parameter int W = 16
) (
    input  logic [W-1:0]   fa,
    input  logic [W-1:0]   fb,
    output logic [2*W-1:0] pr
);
    always_comb begin
        pr = (2*W)'(fa) * (2*W)'(fb);
    end
endmodule

// File: rtl/kmul_merge.sv
module kmul_merge #(
    parameter int HW = 16
) (
    input  logic [2*HW-1:0] p_hh,
    input  logic [2*HW-1:0] p_ll,
    input  logic [2*HW-1:0] p_x,
    input  logic            same_dir,
    output logic [2*HW-1:0] res_hi,
    output logic [2*HW-1:0] res_lo
);
    localparam int WW = 2 * HW;
    localparam int MW = WW + 2;
    localparam int PW = 2 * WW;

    logic [MW-1:0] base_sum;
    logic [MW-1:0] mid;
    logic [PW-1:0] full;

    always_comb begin
        base_sum = MW'(p_hh) + MW'(p_ll);
        if (same_dir) begin
            mid = base_sum - MW'(p_x);
        end else begin
            mid = base_sum + MW'(p_x);
        end
        full   = {p_hh, p_ll} + (PW'(mid) << HW);
        res_hi = full[PW-1:WW];
        res_lo = full[WW-1:0];
    end
endmodule

// File: rtl/karat_mul.sv
module karat_mul
    import kmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] opx,
    input  logic [WORD_W-1:0] opy,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] prod_hi,
    output logic [WORD_W-1:0] prod_lo
);
    kstate_t state_q, state_d;

    logic [WORD_W-1:0] opx_q, opy_q;
    logic [WORD_W-1:0] p_hh_q, p_ll_q;

    // halves: index 0 = first operand, 1 = second operand
    logic [HALF_W-1:0] up_h [2];
    logic [HALF_W-1:0] lo_h [2];
    logic [HALF_W-1:0] mag  [2];
    logic              ge   [2];

    assign up_h[0] = opx_q[WORD_W-1:HALF_W];
    assign lo_h[0] = opx_q[HALF_W-1:0];
    assign up_h[1] = opy_q[WORD_W-1:HALF_W];
    assign lo_h[1] = opy_q[HALF_W-1:0];

    for (genvar g = 0; g < 2; g++) begin : g_diff
        kmul_absdiff #(.W(HALF_W)) u_diff (
            .upper    (up_h[g]),
            .lower    (lo_h[g]),
            .mag      (mag[g]),
            .upper_ge (ge[g])
        );
    end

    logic [HALF_W-1:0] mul_a, mul_b;
    logic [WORD_W-1:0] mul_p;

    always_comb begin
        unique case (state_q)
            S_HIHI: begin
                mul_a = up_h[0];
                mul_b = up_h[1];
            end
            S_LOLO: begin
                mul_a = lo_h[0];
                mul_b = lo_h[1];
            end
            S_CROSS: begin
                mul_a = mag[0];
                mul_b = mag[1];
            end
            default: begin
                mul_a = '0;
                mul_b = '0;
            end
        endcase
    end

    kmul_mult #(.W(HALF_W)) u_mult (
        .fa (mul_a),
        .fb (mul_b),
        .pr (mul_p)
    );

    logic [WORD_W-1:0] mrg_hi, mrg_lo;

    kmul_merge #(.HW(HALF_W)) u_merge (
        .p_hh     (p_hh_q),
        .p_ll     (p_ll_q),
        .p_x      (mul_p),
        .same_dir (ge[0] == ge[1]),
        .res_hi   (mrg_hi),
        .res_lo   (mrg_lo)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_HIHI;
            S_HIHI:  state_d = S_LOLO;
            S_LOLO:  state_d = S_CROSS;
            S_CROSS: state_d = S_FIN;
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opx_q   <= '0;
            opy_q   <= '0;
            p_hh_q  <= '0;
            p_ll_q  <= '0;
            prod_hi <= '0;
            prod_lo <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        opx_q <= opx;
                        opy_q <= opy;
                    end
                end
                S_HIHI:  p_hh_q <= mul_p;
                S_LOLO:  p_ll_q <= mul_p;
                S_CROSS: begin
                    prod_hi <= mrg_hi;
                    prod_lo <= mrg_lo;
                end
                default: ;
            endcase
        end
    end

    assign busy = (state_q != S_IDLE);
    assign done = (state_q == S_FIN);
endmodule

// File: rtl/karat_mul_chk.sv
module karat_mul_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [31:0] prod_hi,
    input logic [31:0] prod_lo,
    input logic [31:0] opx_q,
    input logic [31:0] opy_q
);
    p_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ({prod_hi, prod_lo} == (64'(opx_q) * 64'(opy_q))));

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start && !busy, 4) |-> done);

    p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(opx_q) && $stable(opy_q)));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({prod_hi, prod_lo}) |-> done);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !done);
endmodule

bind karat_mul karat_mul_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .prod_hi (prod_hi),
    .prod_lo (prod_lo),
    .opx_q   (opx_q),
    .opy_q   (opy_q)
);

// File: tb/sim_karat_mul.sv
module sim_karat_mul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] opx = '0;
    logic [31:0] opy = '0;
    logic        busy, done;
    logic [31:0] prod_hi, prod_lo;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    karat_mul u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .opx     (opx),
        .opy     (opy),
        .busy    (busy),
        .done    (done),
        .prod_hi (prod_hi),
        .prod_lo (prod_lo)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] got,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (exp_q.size() != 0) check(1'b0, "R1", 64'(exp_q.size()), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // monitor: pops expected products when done is seen
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1", {prod_hi, prod_lo}, 64'd0);
            end else begin
                logic [63:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({prod_hi, prod_lo} == e, t, {prod_hi, prod_lo}, e);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            check(1'b0, "watchdog", 64'(cyc), 64'd0);
            finish_run();
        end
    end

    // driver: one operation, optional interfering start at cycle 2
    task automatic run_op(input logic [31:0] x, input logic [31:0] y,
                          input string tag, input bit interfere);
        int lat;
        while (busy) @(negedge clk);
        exp_q.push_back(64'(x) * 64'(y));
        tag_q.push_back(tag);
        opx = x;
        opy = y;
        start = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            start = 1'b0;
            opx = ~x;
            opy = y ^ 32'h5A5A_A5A5;
            if (interfere && lat == 2) start = 1'b1; // R4: start while busy
        end while (!done && lat < 10);
        start = 1'b0;
        check(lat == 4, "R2", 64'(lat), 64'd4);
        @(negedge clk);
        check(!done && !busy, "R3", {62'd0, done, busy}, 64'd0);
    endtask

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        check(!busy && !done && prod_hi == 0 && prod_lo == 0, "R10",
              {prod_hi, prod_lo}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !done && prod_hi == 0 && prod_lo == 0, "R10",
              {prod_hi, prod_lo}, 64'd0);

        run_op(32'h0000_0000, 32'h0000_0000, "R9", 1'b0);
        run_op(32'h0000_0000, 32'hFFFF_FFFF, "R9", 1'b0);
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9", 1'b0);
        run_op(32'h9000_1000, 32'hF000_0010, "R6", 1'b0);
        run_op(32'h0001_FFFF, 32'h0100_8000, "R6", 1'b0);
        run_op(32'hFFFF_0001, 32'h0001_FFFF, "R7", 1'b0);
        run_op(32'h0003_C000, 32'hE000_0007, "R7", 1'b0);
        run_op(32'h1234_1234, 32'hBEEF_0042, "R8", 1'b0);
        run_op(32'h0042_ABCD, 32'h7777_7777, "R8", 1'b0);
        run_op(32'hFFFF_FFFF, 32'h8000_8000, "R8", 1'b0);
        run_op(32'hDEAD_BEEF, 32'h0BAD_F00D, "R4", 1'b1);

        // R5: outputs hold while idle with changing inputs
        held = {prod_hi, prod_lo};
        for (int i = 0; i < 6; i++) begin
            opx = $urandom;
            opy = $urandom;
            @(negedge clk);
        end
        check({prod_hi, prod_lo} == held, "R5", {prod_hi, prod_lo}, held);

        for (int i = 0; i < 40; i++) begin
            run_op($urandom, $urandom, "R1", 1'b0);
        end
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule